// File: doc/BRIEF.md
# Fractional Fixed-Point Multiply Unit

This unit is the multiply stage of a DSP datapath. It accepts two 32-bit source words and a mode bit. It multiplies one signed 16-bit half of each word and registers the product one clock later, together with a set of condition flags.

In fractional mode the upper halves are used. The product is treated as a fraction, so it is doubled and placed against the top of the 32-bit result, and its lowest bit is always clear. In integer mode the lower halves are used and the product sits at bit 0. The destination is either a plain 32-bit word or a 40-bit word with eight guard bits. For a 40-bit destination the guard byte carries the sign of bit 31. For a 32-bit destination the guard byte reads zero.

The flags are negative, zero, overflow and greater-than. Overflow and greater-than are always clear after a multiply. When no operation is issued, the result and the flags keep their previous values.

Top module: `frac_mul_unit`

## Requirements
- R1: With `mode`=0 (integer), the result's low 32 bits equal the signed product of `src_a[15:0]` and `src_b[15:0]`. The upper halves of the sources have no effect.
- R2: With `mode`=1 (fractional), the result's low 32 bits equal the signed product of `src_a[31:16]` and `src_b[31:16]`, shifted left by one and truncated to 32 bits. The lower halves of the sources have no effect.
- R3: After a fractional operation, `res[0]` is 0.
- R4: With `guard_dst`=1, every bit of `res[39:32]` equals `res[31]`.
- R5: With `guard_dst`=0, `res[39:32]` is 0.
- R6: `valid_out` is high in exactly the cycle after a cycle with `valid_in` high. The result and flags of that operation are visible in the same cycle.
- R7: After an operation, `flag_n` equals `res[31]`.
- R8: After an operation, `flag_z` is 1 exactly when `res[31:0]` is zero.
- R9: `flag_v` and `flag_gt` are always 0.
- R10: In a cycle with `valid_in` low, `res` and all flags keep their values and `valid_out` goes low.
- R11: While `rst_n` is low at a clock edge, `res`, all flags and `valid_out` are cleared.
- R12: In fractional mode, 0x8000 times 0x8000 wraps to 0x8000_0000 without saturation. The result has `flag_n`=1, `flag_v`=0, and a guard byte of 0xFF when `guard_dst`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Issue an operation this cycle |
| mode | input | 1 | 0 = integer (low halves), 1 = fractional (high halves) |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| guard_dst | input | 1 | 1 = 40-bit destination with sign-extended guard byte |
| res | output | 40 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag, always 0 |
| flag_gt | output | 1 | Greater-than flag, always 0 |
| valid_out | output | 1 | Result and flags were updated on the last edge |

## Verification
Alignment of the product and extension of the guard byte act on the same product in the same cycle as the negative and zero flags are formed. For that reason the sweep pairs every operand value with every other, in both modes and for both destination widths, and checks the guard byte against the sign flag in the same sample. The wrapping fractional corner case is the sharpest point where these meet: the product flips to a negative sign, so it must set N, fill the guard byte with ones and still leave V clear. Each result is judged against products computed arithmetically in the bench. Junk in the unused halves shows whether the wrong halves leak into the product.

// File: rtl/frac_mul_pkg.sv
`timescale 1ns/1ps
// Shared types for the fractional multiply unit.
// Assumes: a single mode bit and a four-bit flag group.
package frac_mul_pkg;

    typedef enum logic {
        MODE_INT  = 1'b0,
        MODE_FRAC = 1'b1
    } mul_mode_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic gt;
    } mul_flags_t;

endpackage

// File: rtl/frac_mul_opsel.sv
`timescale 1ns/1ps
// Operand selector: picks the high halves of both sources in fractional
// mode and the low halves in integer mode.
// Assumes: DATA_W is even; HALF_W is derived from it.
module frac_mul_opsel
    import frac_mul_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  mul_mode_e                 mode,
    input  logic [DATA_W-1:0]         src_a,
    input  logic [DATA_W-1:0]         src_b,
    output logic signed [HALF_W-1:0]  op_a,
    output logic signed [HALF_W-1:0]  op_b
);

    // Select the half of each source that feeds the multiplier.
    always_comb begin
        if (mode == MODE_FRAC) begin
            op_a = src_a[DATA_W-1:HALF_W];
            op_b = src_b[DATA_W-1:HALF_W];
        end else begin
            op_a = src_a[HALF_W-1:0];
            op_b = src_b[HALF_W-1:0];
        end
    end

endmodule

// File: rtl/frac_mul_core.sv
`timescale 1ns/1ps
// Multiply and align core: forms the signed product of two half-width
// operands. A fractional product is shifted left by one so it is
// MSB-aligned; an integer product stays LSB-aligned. It then fills the
// guard bits with the sign or with zero.
// Assumes: purely combinational; the top registers the output.
module frac_mul_core
    import frac_mul_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int GUARD_W = 8,
    localparam int HALF_W = DATA_W / 2,
    localparam int FULL_W = DATA_W + GUARD_W
) (
    input  mul_mode_e                 mode,
    input  logic signed [HALF_W-1:0]  op_a,
    input  logic signed [HALF_W-1:0]  op_b,
    input  logic                      guard_dst,
    output logic [FULL_W-1:0]         res_full
);

    logic signed [DATA_W-1:0] prod;
    logic [DATA_W-1:0]        aligned;

    // Signed product of the selected halves.
    always_comb begin
        prod = op_a * op_b;
    end

    // Fractional results move up one place; integer results stay put.
    always_comb begin
        if (mode == MODE_FRAC) begin
            aligned = {prod[DATA_W-2:0], 1'b0};
        end else begin
            aligned = prod;
        end
    end

    // Guard extension, present only when guard bits exist.
    generate
        if (GUARD_W > 0) begin : g_guard
            always_comb begin
                res_full[DATA_W-1:0] = aligned;
                if (guard_dst) begin
                    res_full[FULL_W-1:DATA_W] = {GUARD_W{aligned[DATA_W-1]}};
                end else begin
                    res_full[FULL_W-1:DATA_W] = '0;
                end
            end
        end else begin : g_noguard
            logic unused_guard;
            always_comb begin
                unused_guard = guard_dst;
                res_full     = aligned;
            end
        end
    endgenerate

endmodule

// File: rtl/frac_mul_flags.sv
`timescale 1ns/1ps
// Flag generator: derives the negative and zero flags from the 32-bit
// result word. Overflow and greater-than are held clear for a multiply.
// Assumes: only the basic result word is inspected, never the guard bits.
module frac_mul_flags
    import frac_mul_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    output mul_flags_t        flags
);

    // Compute the condition flags for the new result.
    always_comb begin
        flags.neg  = word[DATA_W-1];
        flags.zero = (word == '0);
        flags.ovf  = 1'b0;
        flags.gt   = 1'b0;
    end

endmodule

// File: rtl/frac_mul_unit.sv
`timescale 1ns/1ps
// Top of the fractional fixed-point multiply unit. It combines operand
// selection, multiply and align, and flag generation, and registers the
// result, the flags and valid one cycle after valid_in.
// Assumes: synchronous active-low reset; result and flags hold while idle.
module frac_mul_unit
    import frac_mul_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int GUARD_W = 8,
    localparam int HALF_W = DATA_W / 2,
    localparam int FULL_W = DATA_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic              mode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              guard_dst,
    output logic [FULL_W-1:0] res,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_gt,
    output logic              valid_out
);

    mul_mode_e                mode_e;
    logic signed [HALF_W-1:0] op_a;
    logic signed [HALF_W-1:0] op_b;
    logic [FULL_W-1:0]        res_nxt;
    mul_flags_t               flags_nxt;
    mul_flags_t               flags_q;

    // Convert the raw mode pin to the enumerated type.
    always_comb begin
        mode_e = mul_mode_e'(mode);
    end

    frac_mul_opsel #(.DATA_W(DATA_W)) u_opsel (
        .mode  (mode_e),
        .src_a (src_a),
        .src_b (src_b),
        .op_a  (op_a),
        .op_b  (op_b)
    );

    frac_mul_core #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_core (
        .mode      (mode_e),
        .op_a      (op_a),
        .op_b      (op_b),
        .guard_dst (guard_dst),
        .res_full  (res_nxt)
    );

    frac_mul_flags #(.DATA_W(DATA_W)) u_flags (
        .word  (res_nxt[DATA_W-1:0]),
        .flags (flags_nxt)
    );

    // Output register: track valid every cycle; load result and flags only on an issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            res       <= '0;
            flags_q   <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                res     <= res_nxt;
                flags_q <= flags_nxt;
            end
        end
    end

    // Drive the individual flag pins from the flag register.
    always_comb begin
        flag_n  = flags_q.neg;
        flag_z  = flags_q.zero;
        flag_v  = flags_q.ovf;
        flag_gt = flags_q.gt;
    end

endmodule

// File: rtl/frac_mul_unit_chk.sv
`timescale 1ns/1ps
// Assertion checker for frac_mul_unit, attached to it by a bind statement.
// Assumes the default widths: 32-bit word, 8 guard bits.
module frac_mul_unit_chk #(
    parameter int DATA_W  = 32,
    parameter int GUARD_W = 8,
    localparam int FULL_W = DATA_W + GUARD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_in,
    input logic              mode,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              guard_dst,
    input logic [FULL_W-1:0] res,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_v,
    input logic              flag_gt,
    input logic              valid_out
);

    p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    p_valid_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);

    p_lsb_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mode) |=> (res[0] == 1'b0));

    p_guard_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && guard_dst) |=> (res[FULL_W-1:DATA_W] == {GUARD_W{res[DATA_W-1]}}));

    p_guard_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !guard_dst) |=> (res[FULL_W-1:DATA_W] == '0));

    p_neg_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (flag_n == res[DATA_W-1]));

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (flag_z == (res[DATA_W-1:0] == '0)));

    p_flags_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_v && !flag_gt));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(res) && $stable(flag_n) && $stable(flag_z)));

    p_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mode && src_a[DATA_W-1:DATA_W/2] == 16'h8000
                         && src_b[DATA_W-1:DATA_W/2] == 16'h8000)
        |=> (res[DATA_W-1:0] == 32'h8000_0000 && flag_n && !flag_v));

endmodule

bind frac_mul_unit frac_mul_unit_chk #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .mode      (mode),
    .src_a     (src_a),
    .src_b     (src_b),
    .guard_dst (guard_dst),
    .res       (res),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_gt   (flag_gt),
    .valid_out (valid_out)
);

// File: tb/frac_mul_unit_test.sv
`timescale 1ns/1ps
// Sweep bench: every pair from a 16-entry operand set, in both modes and
// for both destination widths, with junk in the unused halves.
module frac_mul_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        guard_dst = 1'b0;
    logic [39:0] res;
    logic        flag_n, flag_z, flag_v, flag_gt, valid_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    frac_mul_unit uut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .mode(mode),
        .src_a(src_a), .src_b(src_b), .guard_dst(guard_dst),
        .res(res), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_gt(flag_gt), .valid_out(valid_out)
    );

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] opval(input int i);
        case (i)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'hFFFF;  3: return 16'h7FFF;
            4: return 16'h8000;  5: return 16'h8001;  6: return 16'h4000;  7: return 16'hC000;
            8: return 16'h0002;  9: return 16'h1234; 10: return 16'hA5A5; 11: return 16'h5A5A;
            12: return 16'h00FF; 13: return 16'hFF00; 14: return 16'h7FFE; default: return 16'h3C3C;
        endcase
    endfunction

    function automatic logic [31:0] next_junk(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    // Issue one operation and check everything one cycle later.
    task automatic run_op(input logic m, input logic g, input logic [15:0] a, input logic [15:0] b);
        logic signed [15:0] sa;
        logic signed [15:0] sb;
        logic signed [31:0] p;
        logic [31:0]        w;
        logic [39:0]        e;
        sa = a; sb = b;
        p  = sa * sb;
        w  = m ? {p[30:0], 1'b0} : p;
        e  = {(g ? {8{w[31]}} : 8'h00), w};
        @(negedge clk);
        lcg = next_junk(lcg);
        mode = m; guard_dst = g; valid_in = 1'b1;
        if (m) begin
            src_a = {a, lcg[15:0]}; src_b = {b, lcg[31:16]};
        end else begin
            src_a = {lcg[15:0], a}; src_b = {lcg[31:16], b};
        end
        @(negedge clk);
        check(m ? "R2 frac result (R4/R5 guard)" : "R1 int result (R4/R5 guard)", res, e);
        check("R7 flag_n", {39'd0, flag_n}, {39'd0, w[31]});
        check("R8 flag_z", {39'd0, flag_z}, {39'd0, (w == 32'd0)});
        check("R9 flag_v/gt", {38'd0, flag_v, flag_gt}, 40'd0);
        check("R6 valid_out", {39'd0, valid_out}, 40'd1);
        if (m) check("R3 lsb zero", {39'd0, res[0]}, 40'd0);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [39:0] held;
        logic        held_n, held_z;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset res", res, 40'd0);
        check("R11 reset flags/valid", {35'd0, flag_n, flag_z, flag_v, flag_gt, valid_out}, 40'd0);
        rst_n = 1'b1;

        // R12: wrapping corner case with guard bits
        run_op(1'b1, 1'b1, 16'h8000, 16'h8000);
        check("R12 wrap result", res, 40'hFF_8000_0000);
        check("R12 wrap flags", {37'd0, flag_n, flag_v, flag_gt}, {37'd0, 3'b100});

        // Sweep of R1/R2/R4/R5/R7/R8/R9
        for (int mi = 0; mi < 2; mi++)
            for (int gi = 0; gi < 2; gi++)
                for (int i = 0; i < 16; i++)
                    for (int j = 0; j < 16; j++)
                        run_op(mi[0], gi[0], opval(i), opval(j));

        // R10: idle cycles hold result and flags, valid_out falls
        run_op(1'b0, 1'b1, 16'hFFFF, 16'h0003);
        held = res; held_n = flag_n; held_z = flag_z;
        valid_in = 1'b0; mode = 1'b1; guard_dst = 1'b0;
        src_a = '0; src_b = '0;
        @(negedge clk);
        check("R10 hold res", res, held);
        check("R10 hold flags", {38'd0, flag_n, flag_z}, {38'd0, held_n, held_z});
        check("R6 valid_out low when idle", {39'd0, valid_out}, 40'd0);
        @(negedge clk);
        check("R10 hold res second idle", res, held);

        // R11: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset after run", {res, 3'd0}, {40'd0, 3'd0});
        check("R11 reset flags after run", {35'd0, flag_n, flag_z, flag_v, flag_gt, valid_out}, 40'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule